// File: doc/BRIEF.md
# Frame Fetch Address Sequencer

This block works out which display-memory bursts a display controller must fetch, and when. Software sets a load mode, a burst-length code, a pixel depth, a palette base address and one or two buffer regions. Each region is given as a base byte address and an inclusive last-byte address. Once enabled, the block walks the palette region, the data region, or both, in bursts of 32-bit words. It offers each burst on a request/grant read port, and only when the display FIFO has room for the whole burst. In dual-buffer mode successive frames alternate between the two regions.

A status word collects events: palette load complete, end of frame for each buffer, FIFO underflow (the raster side asks for a pixel while the FIFO is empty), and sync lost. Software clears a flag by writing a one to its bit. The read port follows valid/ready rules. Once `rd_valid` is high it stays high, with `rd_addr` and `rd_len` unchanged, until the cycle in which `rd_ready` is high. The handshake completes at that clock edge. A low `rd_ready` stalls the sequencer without losing the request. The memory, the pixel unpacking and the raster timing lie outside the block.

Top module: `fb_fetch_seq`

## Requirements
- R1: The burst code maps 0, 1, 2, 3, 4 to 1, 2, 4, 8, 16 words, and no burst is longer than the coded length. With codes 5, 6 or 7 no request is made.
- R2: A raised `rd_valid` holds, with stable `rd_addr` and `rd_len`, until granted. Each granted burst moves the next address on by 4 × `rd_len` bytes.
- R3: A request is raised only if FIFO_DEPTH − `fifo_level` ≥ the burst length.
- R4: Region ceilings are inclusive. The final burst of a region is shortened so that the last byte read is the ceiling byte, never beyond it.
- R5: The palette region starts at `cfg_pal_base`. It is 32 bytes for `cfg_bpp` 1, 2, 4 or 16, and 512 bytes for `cfg_bpp` 8.
- R6: `cfg_load_mode` 0 fetches the palette and then data. Mode 1 fetches the palette once and then stops. Mode 2 fetches data only. Mode 3 makes no request.
- R7: Granting the last palette burst sets status bit 6. In mode 0 the first data request comes only after that grant.
- R8: With `cfg_dual` = 1, frames alternate buffer 0, buffer 1, buffer 0, and so on. Finishing buffer 0 sets status bit 8, and finishing buffer 1 sets status bit 9.
- R9: With `cfg_dual` = 0, buffer 0 is fetched every frame and sets bit 8. A change to its base or ceiling takes effect at the next frame start.
- R10: `pix_req` while `fifo_level` = 0 sets status bit 5, and `pix_req` with a non-zero level leaves it clear. A `sync_lost` pulse sets bit 2.
- R11: A `stat_clr_we` cycle clears every status bit that is one in `stat_clr_data`. A flag set in the same cycle as its clear stays set.
- R12: After reset `rd_valid` is 0 and `status` is 0.
- R13: With `cfg_enable` low, no new request is raised once any pending request is granted. Raising it again restarts at the first region of the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Run the sequencer |
| cfg_load_mode | input | 2 | 0 palette+data, 1 palette only, 2 data only |
| cfg_dual | input | 1 | Alternate buffers 0 and 1 |
| cfg_burst_code | input | 3 | Burst length code |
| cfg_bpp | input | 5 | Pixel depth in bits |
| cfg_pal_base | input | AW | Palette base byte address |
| cfg_base0 | input | AW | Buffer 0 base byte address |
| cfg_ceil0 | input | AW | Buffer 0 last byte address |
| cfg_base1 | input | AW | Buffer 1 base byte address |
| cfg_ceil1 | input | AW | Buffer 1 last byte address |
| fifo_level | input | LW | Words held or reserved in the display FIFO |
| pix_req | input | 1 | Raster side takes a pixel word |
| sync_lost | input | 1 | Sync-lost event pulse |
| rd_valid | output | 1 | Burst request valid |
| rd_ready | input | 1 | Burst request granted |
| rd_addr | output | AW | Burst start byte address |
| rd_len | output | 5 | Burst length in words |
| stat_clr_we | input | 1 | Status clear strobe |
| stat_clr_data | input | 16 | Ones clear the matching status bits |
| status | output | 16 | Status flags (bits 2, 5, 6, 8, 9) |

## Verification
Two pairs of events can land in the same cycle, and the bench provokes both. The first is an event setting a status flag while software writes a one to that same flag. The bench drives `pix_req` with an empty FIFO and a clear of bit 5 in one cycle, and expects bit 5 to remain set. The second is a stalled request meeting a change of buffer configuration. With `rd_ready` held low, the bench rewrites the buffer-0 base. It expects the pending burst to keep the old address, and the next frame to start at the new one.

// File: rtl/fbf_pkg.sv
package fbf_pkg;
  localparam int STAT_W  = 16;
  localparam int LENW    = 5;
  localparam int B_SYNC  = 2;
  localparam int B_UFLOW = 5;
  localparam int B_PDONE = 6;
  localparam int B_EOF0  = 8;
  localparam int B_EOF1  = 9;

  typedef enum logic [2:0] {
    S_IDLE, S_PSTART, S_PAL, S_DSTART, S_DATA, S_HOLD
  } fbf_state_e;

  function automatic logic [LENW-1:0] burst_words(input logic [2:0] code);
    case (code)
      3'd0:    burst_words = 5'd1;
      3'd1:    burst_words = 5'd2;
      3'd2:    burst_words = 5'd4;
      3'd3:    burst_words = 5'd8;
      3'd4:    burst_words = 5'd16;
      default: burst_words = 5'd0;
    endcase
  endfunction
endpackage

// File: rtl/fbf_burst_calc.sv
module fbf_burst_calc #(
  parameter int AW = 32
) (
  input  logic [AW-1:0]            addr,
  input  logic [AW-1:0]            ceil,
  input  logic [2:0]               code,
  output logic [fbf_pkg::LENW-1:0] len,
  output logic                     last,
  output logic                     ok
);
  import fbf_pkg::*;
  logic [AW-1:0]   rem_words;
  logic [LENW-1:0] bw;

  always_comb begin
    rem_words = (ceil - addr + AW'(1)) >> 2;
    bw        = burst_words(code);
    last      = rem_words <= AW'(bw);
    len       = last ? rem_words[LENW-1:0] : bw;
    ok        = (bw != '0) && (rem_words != '0);
  end
endmodule

// File: rtl/fbf_status.sv
module fbf_status #(
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] set_vec,
  input  logic          clr_we,
  input  logic [SW-1:0] clr_data,
  output logic [SW-1:0] stat
);
  always_ff @(posedge clk) begin
    if (!rst_n) stat <= '0;
    else        stat <= (stat & ~(clr_we ? clr_data : '0)) | set_vec;
  end

  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> (($past(set_vec) & ~stat) == '0));
  a_r11_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((stat & $past(clr_data & ~set_vec)) == '0));
endmodule

// File: rtl/fb_fetch_seq.sv
module fb_fetch_seq #(
  parameter int AW         = 32,
  parameter int FIFO_DEPTH = 64,
  parameter int LW         = $clog2(FIFO_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_enable,
  input  logic [1:0]    cfg_load_mode,
  input  logic          cfg_dual,
  input  logic [2:0]    cfg_burst_code,
  input  logic [4:0]    cfg_bpp,
  input  logic [AW-1:0] cfg_pal_base,
  input  logic [AW-1:0] cfg_base0,
  input  logic [AW-1:0] cfg_ceil0,
  input  logic [AW-1:0] cfg_base1,
  input  logic [AW-1:0] cfg_ceil1,
  input  logic [LW-1:0] fifo_level,
  input  logic          pix_req,
  input  logic          sync_lost,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [AW-1:0] rd_addr,
  output logic [4:0]    rd_len,
  input  logic          stat_clr_we,
  input  logic [15:0]   stat_clr_data,
  output logic [15:0]   status
);
  import fbf_pkg::*;

  fbf_state_e      state;
  logic [AW-1:0]   cur_addr, cur_ceil, pal_bytes;
  logic            buf_sel, req_q, last_q, grant;
  logic [LENW-1:0] calc_len;
  logic            calc_last, calc_ok, room_ok;
  logic [LW:0]     room;
  logic [STAT_W-1:0] set_vec;

  fbf_burst_calc #(.AW(AW)) u_calc (
    .addr(cur_addr), .ceil(cur_ceil), .code(cfg_burst_code),
    .len(calc_len), .last(calc_last), .ok(calc_ok)
  );

  always_comb begin
    pal_bytes = (cfg_bpp == 5'd8) ? AW'(512) : AW'(32);
    room      = (LW+1)'(FIFO_DEPTH) - {1'b0, fifo_level};
    room_ok   = room >= (LW+1)'(calc_len);
    grant     = req_q && rd_ready;
    set_vec   = '0;
    set_vec[B_PDONE] = grant && last_q && (state == S_PAL);
    set_vec[B_EOF0]  = grant && last_q && (state == S_DATA) && !buf_sel;
    set_vec[B_EOF1]  = grant && last_q && (state == S_DATA) && buf_sel;
    set_vec[B_UFLOW] = pix_req && (fifo_level == '0);
    set_vec[B_SYNC]  = sync_lost;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cur_addr <= '0;
      cur_ceil <= '0;
      buf_sel  <= 1'b0;
      req_q    <= 1'b0;
      last_q   <= 1'b0;
      rd_addr  <= '0;
      rd_len   <= '0;
    end else begin
      if (grant) begin
        req_q    <= 1'b0;
        cur_addr <= cur_addr + (AW'(rd_len) << 2);
      end
      case (state)
        S_IDLE: begin
          buf_sel <= 1'b0;
          if (cfg_enable) begin
            if (cfg_load_mode == 2'd0 || cfg_load_mode == 2'd1) state <= S_PSTART;
            else if (cfg_load_mode == 2'd2)                     state <= S_DSTART;
          end
        end
        S_PSTART: begin
          cur_addr <= cfg_pal_base;
          cur_ceil <= cfg_pal_base + pal_bytes - AW'(1);
          state    <= S_PAL;
        end
        S_DSTART: begin
          cur_addr <= buf_sel ? cfg_base1 : cfg_base0;
          cur_ceil <= buf_sel ? cfg_ceil1 : cfg_ceil0;
          state    <= S_DATA;
        end
        S_PAL, S_DATA: begin
          if (!req_q && cfg_enable && calc_ok && room_ok) begin
            req_q   <= 1'b1;
            rd_addr <= cur_addr;
            rd_len  <= calc_len;
            last_q  <= calc_last;
          end
          if (grant && last_q) begin
            if (state == S_PAL) begin
              state <= (cfg_load_mode == 2'd0) ? S_DSTART : S_HOLD;
            end else begin
              buf_sel <= cfg_dual ? ~buf_sel : 1'b0;
              state   <= S_DSTART;
            end
          end
        end
        default: ;
      endcase
      if (!cfg_enable && !req_q) state <= S_IDLE;
    end
  end

  assign rd_valid = req_q;

  fbf_status #(.SW(STAT_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
    .clr_we(stat_clr_we), .clr_data(stat_clr_data), .stat(status)
  );

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr) && $stable(rd_len)));
  a_r1_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_len >= 5'd1 && rd_len <= 5'd16));
  a_r3_room: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> (32'($past(fifo_level)) + 32'(rd_len) <= 32'(FIFO_DEPTH)));
  a_r4_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (AW'(rd_addr + (AW'(rd_len) << 2) - AW'(1)) <= cur_ceil));
endmodule

// File: tb/test_fb_fetch_seq.sv
`timescale 1ns/1ps
module test_fb_fetch_seq;
  localparam int AW = 32;
  localparam int DEPTH = 64;
  localparam int LW = $clog2(DEPTH + 1);
  localparam logic [31:0] PAL = 32'h1000;

  logic clk = 0, rst_n = 0;
  logic cfg_enable = 0, cfg_dual = 0;
  logic [1:0] cfg_load_mode = 0;
  logic [2:0] cfg_burst_code = 0;
  logic [4:0] cfg_bpp = 16;
  logic [AW-1:0] cfg_pal_base = PAL, cfg_base0 = 0, cfg_ceil0 = 0, cfg_base1 = 0, cfg_ceil1 = 0;
  logic [LW-1:0] fifo_level = 0;
  logic pix_req = 0, sync_lost = 0, rd_ready = 1, stat_clr_we = 0;
  logic [15:0] stat_clr_data = 0;
  logic rd_valid;
  logic [AW-1:0] rd_addr;
  logic [4:0] rd_len;
  logic [15:0] status;

  always #4 clk = ~clk;

  fb_fetch_seq i_fb_fetch_seq (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_load_mode(cfg_load_mode),
    .cfg_dual(cfg_dual), .cfg_burst_code(cfg_burst_code), .cfg_bpp(cfg_bpp),
    .cfg_pal_base(cfg_pal_base), .cfg_base0(cfg_base0), .cfg_ceil0(cfg_ceil0),
    .cfg_base1(cfg_base1), .cfg_ceil1(cfg_ceil1), .fifo_level(fifo_level),
    .pix_req(pix_req), .sync_lost(sync_lost), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .rd_len(rd_len), .stat_clr_we(stat_clr_we),
    .stat_clr_data(stat_clr_data), .status(status)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic mon_clr = 0;
  int gcnt = 0;
  logic [31:0] g_addr [64];
  logic [4:0]  g_len  [64];

  always @(negedge clk) begin
    if (mon_clr) gcnt = 0;
    else if (rd_valid && rd_ready && gcnt < 64) begin
      g_addr[gcnt] = rd_addr;
      g_len[gcnt]  = rd_len;
      gcnt = gcnt + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #6;
  endtask

  task automatic start_run(input logic [1:0] mode, input logic [2:0] code, input logic [4:0] bpp,
                           input logic dual, input logic [31:0] b0, c0, b1, c1, input logic rdy);
    @(posedge clk); #2;
    cfg_enable = 0; rd_ready = 1;
    cyc(4);
    @(posedge clk); #2;
    cfg_load_mode = mode; cfg_burst_code = code; cfg_bpp = bpp; cfg_dual = dual;
    cfg_base0 = b0; cfg_ceil0 = c0; cfg_base1 = b1; cfg_ceil1 = c1;
    mon_clr = 1; stat_clr_we = 1; stat_clr_data = 16'hFFFF;
    @(posedge clk); #2;
    mon_clr = 0; stat_clr_we = 0; stat_clr_data = 0;
    cfg_enable = 1; rd_ready = rdy;
  endtask

  task automatic wait_g(input int n);
    for (int i = 0; i < 3000 && gcnt < n; i++) cyc(1);
  endtask

  typedef struct packed {
    logic [1:0] mode; logic [2:0] code; logic [4:0] bpp;
    logic [31:0] base; logic [31:0] ceil; logic [7:0] nb;
    logic [4:0] flen; logic [31:0] laddr; logic [4:0] llen;
  } vec_t;

  localparam vec_t TBL [6] = '{
    '{2'd2, 3'd2, 5'd16, 32'h2000, 32'h203F, 8'd4,  5'd4,  32'h2030, 5'd4},
    '{2'd2, 3'd4, 5'd16, 32'h2000, 32'h2057, 8'd2,  5'd16, 32'h2040, 5'd6},
    '{2'd1, 3'd3, 5'd8,  32'h0,    32'h0,    8'd16, 5'd8,  32'h11E0, 5'd8},
    '{2'd1, 3'd4, 5'd4,  32'h0,    32'h0,    8'd1,  5'd8,  32'h1000, 5'd8},
    '{2'd2, 3'd0, 5'd16, 32'h3000, 32'h300B, 8'd3,  5'd1,  32'h3008, 5'd1},
    '{2'd1, 3'd1, 5'd16, 32'h0,    32'h0,    8'd4,  5'd2,  32'h1018, 5'd2}
  };

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual hung expected finish");
    finish_up();
  end

  initial begin
    cyc(3);
    chk("R12 rd_valid", {31'd0, rd_valid}, 0);
    chk("R12 status", {16'd0, status}, 0);
    @(posedge clk); #2 rst_n = 1;
    cyc(2);

    // R1 R4 R5 R6 R7 R9: table walk
    foreach (TBL[k]) begin
      vec_t v = TBL[k];
      start_run(v.mode, v.code, v.bpp, 1'b0, v.base, v.ceil, 0, 0, 1'b1);
      wait_g(int'(v.nb));
      chk("R5/R2 first addr", g_addr[0], (v.mode == 2'd1) ? PAL : v.base);
      chk("R1 first len", {27'd0, g_len[0]}, {27'd0, v.flen});
      chk("R4 last addr", g_addr[v.nb - 1], v.laddr);
      chk("R4 last len", {27'd0, g_len[v.nb - 1]}, {27'd0, v.llen});
      cyc(30);
      if (v.mode == 2'd1) begin
        chk("R6 palette only stops", gcnt, int'(v.nb));
        chk("R7 palette done", {31'd0, status[6]}, 1);
      end else begin
        chk("R9 eof0 set", {31'd0, status[8]}, 1);
      end
    end

    // R6 R7: palette then data
    start_run(2'd0, 3'd4, 5'd4, 1'b0, 32'h2000, 32'h203F, 0, 0, 1'b1);
    wait_g(2);
    chk("R7 palette first", g_addr[0], PAL);
    chk("R6 data after palette", g_addr[1], 32'h2000);
    chk("R7 status bit6", {31'd0, status[6]}, 1);

    // R6 mode 3, R1 bad code
    start_run(2'd3, 3'd2, 5'd16, 1'b0, 32'h2000, 32'h203F, 0, 0, 1'b1);
    cyc(40);
    chk("R6 mode3 no request", gcnt, 0);
    start_run(2'd2, 3'd5, 5'd16, 1'b0, 32'h2000, 32'h203F, 0, 0, 1'b1);
    cyc(40);
    chk("R1 code5 no request", gcnt, 0);

    // R8 dual alternation
    start_run(2'd2, 3'd3, 5'd16, 1'b1, 32'h2000, 32'h201F, 32'h4000, 32'h401F, 1'b1);
    wait_g(3);
    cyc(2);
    chk("R8 frame0", g_addr[0], 32'h2000);
    chk("R8 frame1", g_addr[1], 32'h4000);
    chk("R8 frame2", g_addr[2], 32'h2000);
    chk("R8 eof bits", {30'd0, status[9:8]}, 3);

    // R13 disable stops
    @(posedge clk); #2 cfg_enable = 0;
    cyc(4);
    @(posedge clk); #2 mon_clr = 1;
    @(posedge clk); #2 mon_clr = 0;
    cyc(30);
    chk("R13 disabled no grants", gcnt, 0);

    // R9 R2: stalled request while base changes
    start_run(2'd2, 3'd3, 5'd16, 1'b0, 32'h2000, 32'h201F, 0, 0, 1'b0);
    for (int i = 0; i < 20 && !rd_valid; i++) cyc(1);
    chk("R2 pending addr", rd_addr, 32'h2000);
    @(posedge clk); #2 cfg_base0 = 32'h5000; cfg_ceil0 = 32'h501F;
    cyc(5);
    chk("R2 held valid", {31'd0, rd_valid}, 1);
    chk("R2 held addr", rd_addr, 32'h2000);
    @(posedge clk); #2 rd_ready = 1;
    wait_g(2);
    chk("R9 old frame", g_addr[0], 32'h2000);
    chk("R9 new base next frame", g_addr[1], 32'h5000);

    // R3 FIFO room
    @(posedge clk); #2 fifo_level = LW'(DEPTH - 3);
    start_run(2'd2, 3'd2, 5'd16, 1'b0, 32'h2000, 32'h203F, 0, 0, 1'b1);
    cyc(20);
    chk("R3 no room no request", gcnt, 0);
    @(posedge clk); #2 fifo_level = LW'(DEPTH - 4);
    cyc(4);
    chk("R3 room request", {31'd0, (gcnt > 0)}, 1);

    // R10 R11 status flags
    @(posedge clk); #2 cfg_enable = 0; fifo_level = 0;
    cyc(4);
    @(posedge clk); #2 stat_clr_we = 1; stat_clr_data = 16'hFFFF;
    @(posedge clk); #2 stat_clr_we = 0; stat_clr_data = 0; pix_req = 1;
    @(posedge clk); #2 pix_req = 0; sync_lost = 1;
    @(posedge clk); #2 sync_lost = 0;
    #4;
    chk("R10 underflow bit5", {31'd0, status[5]}, 1);
    chk("R10 sync lost bit2", {31'd0, status[2]}, 1);
    @(posedge clk); #2 stat_clr_we = 1; stat_clr_data = 16'h0024;
    @(posedge clk); #2 stat_clr_we = 0; stat_clr_data = 0;
    #4;
    chk("R11 w1c clears", {16'd0, status & 16'h0024}, 0);
    @(posedge clk); #2 fifo_level = 5; pix_req = 1;
    @(posedge clk); #2 pix_req = 0; fifo_level = 0;
    #4;
    chk("R10 nonempty no underflow", {31'd0, status[5]}, 0);
    @(posedge clk); #2 pix_req = 1; stat_clr_we = 1; stat_clr_data = 16'h0020;
    @(posedge clk); #2 pix_req = 0; stat_clr_we = 0; stat_clr_data = 0;
    #4;
    chk("R11 set wins over clear", {31'd0, status[5]}, 1);

    finish_up();
  end
endmodule